// File: doc/BRIEF.md
# SPI Slave Register Access Port

This block lets an external SPI master read and write a 256-entry bank of 8-bit registers through a four-wire serial link. The serial pins are not used as a clock. They are sampled by the faster system clock through two-flop synchronizers, and the block acts on edges that it detects in that domain. The system clock must run at least eight times faster than SCLK. The bus runs in mode 0: SCLK idles low, the slave captures MOSI on the rising edge and changes MISO after the falling edge.

Each transaction starts when chip select goes low and ends when it goes high. The first two bytes form a command header. The first bit sent selects the direction, and the address is spread over both header bytes: seven low bits in the first byte and the top bit at the front of the second. From the third byte on, data bytes stream in either direction. The register address steps forward after every full byte. MISO is always driven, so the block is intended for a bus with one master and this one slave.

Top module: `spi_regport`

## Requirements
- R1: A low level on the chip-select pin (`spi_cs_n`) opens a frame. A return to high at any point closes the frame. The next frame decodes its header from its own first bit, whatever state the earlier frame was left in.
- R2: The first bit of header byte 0 selects the direction: 1 means write and 0 means read. Its remaining seven bits are address bits 6..0, sent MSB first.
- R3: The first bit of header byte 1 is address bit 7. The other seven bits of that byte have no effect on the access.
- R4: In a write frame, each complete byte from the third byte on, sent MSB first, is stored in the addressed register. There is exactly one store per byte.
- R5: If chip select rises while a data byte has fewer than 8 bits, that byte is discarded and no register changes.
- R6: After every completed data byte the address increases by one, in reads and in writes, and 0xFF is followed by 0x00.
- R7: In a read frame, from the third byte on, the addressed register is shifted out on MISO MSB first. MISO changes only after an SCLK falling edge, so the master can sample it on the next rising edge.
- R8: MISO is driven low whenever chip select is high, during both header bytes, and during write frames.
- R9: After a synchronous reset MISO is low and the frame decoder is idle. Transfers work with an SCLK period as short as 8 system clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from the master (idles low) |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master, always driven |

## Verification
Every read byte is compared bit for bit against a register model kept by the bench. A wrong address latch, a missed increment or a stray store therefore shows up as a data mismatch on MISO in the first read frame that touches the affected register. A bit-count or header-phase error shifts all later bytes of the same frame, so it shows up within one byte. MISO is also sampled during header bytes and while chip select is idle, so a transmit register that is not cleared or is loaded too early is caught in the very next frame.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;

  // Position of the current byte within a frame
  typedef enum logic [1:0] {
    PH_CMD   = 2'd0,  // direction flag + low address bits
    PH_ADRHI = 2'd1,  // top address bit + ignored bits
    PH_DATA  = 2'd2   // streaming data bytes
  } phase_e;

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int             W       = 3,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
    end else begin
      stg[0] <= din;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/spi_regfile.sv
module spi_regfile #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Simple dual-port, registered read: maps onto block RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end

  // Stores come from completed serial bytes, so never back to back
  AST_WR_SPACED: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);  // R4

endmodule

// File: rtl/spi_frame.sv
module spi_frame
  import spi_regport_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_hi,
  input  logic          sclk_lvl,
  input  logic          mosi_bit,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          miso_bit
);

  localparam int CNT_W = $clog2(DW);

  logic             sclk_prev;
  logic             sclk_rise, sclk_fall;
  logic [CNT_W-1:0] bit_cnt;
  logic [DW-1:0]    rx_sh, rx_next;
  logic [DW-1:0]    tx_sh;
  logic [AW-1:0]    addr;
  logic             is_wr;
  logic             load_pend;
  logic             byte_done;
  phase_e           phase;

  assign sclk_rise = sclk_lvl & ~sclk_prev;
  assign sclk_fall = ~sclk_lvl & sclk_prev;
  assign rx_next   = {rx_sh[DW-2:0], mosi_bit};
  assign byte_done = sclk_rise && !cs_hi && (bit_cnt == CNT_W'(DW-1));

  always_ff @(posedge clk) begin
    if (rst) sclk_prev <= 1'b0;
    else     sclk_prev <= sclk_lvl;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt   <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      addr      <= '0;
      is_wr     <= 1'b0;
      load_pend <= 1'b0;
      phase     <= PH_CMD;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else if (cs_hi) begin
      bit_cnt   <= '0;
      tx_sh     <= '0;
      load_pend <= 1'b0;
      phase     <= PH_CMD;
      wr_en     <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (sclk_rise) begin
        rx_sh   <= rx_next;
        bit_cnt <= byte_done ? '0 : bit_cnt + 1'b1;
      end
      if (byte_done) begin
        unique case (phase)
          PH_CMD: begin
            is_wr          <= rx_next[DW-1];
            addr[AW-2:0]   <= rx_next[DW-2:0];
            phase          <= PH_ADRHI;
          end
          PH_ADRHI: begin
            addr[AW-1]     <= rx_next[DW-1];
            phase          <= PH_DATA;
            load_pend      <= !is_wr;
          end
          default: begin
            addr <= addr + 1'b1;
            if (is_wr) begin
              wr_en   <= 1'b1;
              wr_addr <= addr;
              wr_data <= rx_next;
            end else begin
              load_pend <= 1'b1;
            end
          end
        endcase
      end
      if (sclk_fall) begin
        if (load_pend) begin
          tx_sh     <= rd_data;
          load_pend <= 1'b0;
        end else begin
          tx_sh <= {tx_sh[DW-2:0], 1'b0};
        end
      end
    end
  end

  assign rd_addr  = addr;
  assign miso_bit = tx_sh[DW-1];

  AST_BITCNT_CLR: assert property (@(posedge clk) disable iff (rst)
    cs_hi |=> (bit_cnt == '0));  // R1

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (byte_done && phase == PH_DATA) |=> (addr == AW'($past(addr) + 1'b1)));  // R6

  AST_WR_FULL_BYTE: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(byte_done));  // R5

endmodule

// File: rtl/spi_regport.sv
module spi_regport #(
  parameter int AW          = 8,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic spi_sclk,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic spi_miso
);

  logic [2:0]    pins_s;
  logic          cs_hi, sclk_s, mosi_s;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [DW-1:0] rd_data, wr_data;
  logic          wr_en;
  logic          miso_bit;

  spi_sync #(
    .W       (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b100)
  ) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({spi_cs_n, spi_sclk, spi_mosi}),
    .dout (pins_s)
  );

  assign cs_hi  = pins_s[2];
  assign sclk_s = pins_s[1];
  assign mosi_s = pins_s[0];

  spi_frame #(.AW(AW), .DW(DW)) u_frame (
    .clk      (clk),
    .rst      (rst),
    .cs_hi    (cs_hi),
    .sclk_lvl (sclk_s),
    .mosi_bit (mosi_s),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .miso_bit (miso_bit)
  );

  spi_regfile #(.AW(AW), .DW(DW)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  assign spi_miso = miso_bit;

  AST_MISO_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    (cs_hi && $past(cs_hi)) |-> !spi_miso);  // R8

  AST_NO_STORE_IDLE: assert property (@(posedge clk) disable iff (rst)
    (cs_hi && $past(cs_hi)) |-> !wr_en);  // R1

endmodule

// File: tb/spi_regport_tb.sv
`timescale 1ns/1ps
module spi_regport_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0;
  logic cs_n = 1'b1;
  logic mosi = 1'b0;
  logic miso;

  int checks = 0;
  int fails  = 0;
  int half   = 8;
  logic [7:0] model [256];

  always #10 clk = ~clk;

  spi_regport u_dut (
    .clk      (clk),
    .rst      (rst),
    .spi_sclk (sclk),
    .spi_cs_n (cs_n),
    .spi_mosi (mosi),
    .spi_miso (miso)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic xfer_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = '0;
    for (int i = 0; i < nbits; i++) begin
      mosi = tx[7-i];
      tick(half);
      sclk = 1'b1;
      rx = {rx[6:0], miso};
      tick(half);
      sclk = 1'b0;
    end
  endtask

  task automatic frame(input bit wr, input logic [7:0] a, input logic [6:0] junk,
                       input int n, input int partial, input string tag);
    logic [7:0] rx, d, ad;
    cs_n = 1'b0;
    tick(half);
    xfer_bits({wr, a[6:0]}, 8, rx);
    check(rx == 8'h00, "R8 header0", rx, 8'h00);
    xfer_bits({a[7], junk}, 8, rx);
    check(rx == 8'h00, "R8 header1", rx, 8'h00);
    for (int i = 0; i < n; i++) begin
      ad = a + 8'(i);
      if (wr) begin
        d = 8'($urandom);
        xfer_bits(d, 8, rx);
        model[ad] = d;
      end else begin
        xfer_bits(8'($urandom), 8, rx);
        check(rx === model[ad], tag, rx, model[ad]);
      end
    end
    if (partial > 0) xfer_bits(8'($urandom), partial, rx);
    tick(half);
    cs_n = 1'b1;
    tick(2 * half);
    check(miso == 1'b0, "R8 idle", {7'd0, miso}, 8'h00);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] rx;
    void'($urandom(32'h5eed_1234));
    tick(5);
    rst = 1'b0;
    tick(2);
    // R9: reset state
    check(miso == 1'b0, "R9 reset miso", {7'd0, miso}, 8'h00);

    // R6: fill every register, start high so the address wraps
    frame(1'b1, 8'h80, 7'h2a, 256, 0, "R4");
    frame(1'b0, 8'hf0, 7'h00, 32, 0, "R6 read wrap");
    frame(1'b1, 8'hfe, 7'h11, 4, 0, "R6");
    frame(1'b0, 8'hfd, 7'h33, 6, 0, "R6 write wrap");

    // R2/R3: address bit 7 from byte 1, the rest of byte 1 ignored
    frame(1'b1, 8'h05, 7'h7f, 1, 0, "R3");
    frame(1'b1, 8'h85, 7'h7f, 1, 0, "R3");
    frame(1'b0, 8'h05, 7'h55, 1, 0, "R3 low half");
    frame(1'b0, 8'h85, 7'h00, 1, 0, "R3 high half");
    frame(1'b0, 8'h04, 7'h7f, 3, 0, "R2");

    // R4: multi-byte write then read back
    frame(1'b1, 8'h20, 7'h01, 5, 0, "R4");
    frame(1'b0, 8'h20, 7'h02, 5, 0, "R4 readback");

    // R5: partial trailing byte is dropped
    frame(1'b1, 8'h40, 7'h03, 1, 5, "R5");
    frame(1'b0, 8'h40, 7'h04, 2, 0, "R5 partial dropped");
    frame(1'b1, 8'h50, 7'h05, 0, 7, "R5");
    frame(1'b0, 8'h50, 7'h06, 1, 0, "R5 partial dropped");

    // R1: header cut short by chip select, then a clean frame
    cs_n = 1'b0;
    tick(half);
    xfer_bits(8'hff, 8, rx);
    xfer_bits(8'hff, 4, rx);
    tick(half);
    cs_n = 1'b1;
    tick(2 * half);
    frame(1'b0, 8'h10, 7'h00, 2, 0, "R1 after abort");
    frame(1'b0, 8'h7f, 7'h00, 2, 0, "R1 after abort");

    // R7: random mix of reads and writes
    for (int k = 0; k < 40; k++) begin
      bit wr;
      wr = 1'($urandom);
      frame(wr, 8'($urandom), 7'($urandom), 1 + int'($urandom % 6),
            wr ? int'($urandom % 8) : 0, "R7");
    end

    // R9: fastest supported SCLK, period of 8 system clocks
    half = 4;
    frame(1'b1, 8'hc0, 7'h09, 3, 0, "R9");
    frame(1'b0, 8'hbf, 7'h0a, 5, 0, "R9 fast sclk");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule